// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block maps the 64 KB address space of a 16-bit processor onto a larger RAM built from 16 KB blocks. The processor address is split into four windows of 16 KB each, chosen by address bits 15:14. Each window has an 8-bit slot register that software loads with an I/O output cycle. The mapper produces the physical block number, the offset within the block, and the flat physical RAM address for every processor access. The processor and the RAM array are outside the block.

A slot works in one of two encodings. In the wide encoding, one block number serves both reads and writes. In the legacy encoding, the slot holds a separate block for reads and a separate block for writes, and both are limited to the first eight blocks. A shared lock register holds one bit per window. When a window in the legacy encoding is locked, its reads are taken from its write block. The fitted RAM size is a power-of-two parameter. Block numbers larger than the fitted size wrap onto the fitted blocks by dropping their high bits.

Top module: `mem_bank_mapper`

## Requirements
- R1: After reset, slot k holds 80h+k (wide encoding, block k) and all lock bits are clear, so window k (address bits 15:14 = k) maps to block k for both reads and writes.
- R2: An I/O write with port F0h+k (k = 0..3, all 8 port bits compared) loads slot k from the data bus at the clock edge. The new mapping is visible from the next cycle on. Address bits 15:14 pick the slot used for an access.
- R3: A slot value with bit 7 = 1 selects the wide encoding. Bits 6:0 give the block for both reads and writes.
- R4: A wide block number at or above BLOCK_COUNT is reduced to its low log2(BLOCK_COUNT) bits. For example, 24 becomes 8 when BLOCK_COUNT is 16.
- R5: A slot value with bit 7 = 0 selects the legacy encoding. Bits 6:4 give the read block, bits 2:0 give the write block, and bit 3 has no effect.
- R6: An I/O write to port F4h loads the lock bits. Data bit 4+k locks window k. Data bits 3:0 have no effect.
- R7: A locked window in the legacy encoding takes its read block from bits 2:0. A lock bit has no effect on a window in the wide encoding.
- R8: blk_offset equals cpu_addr[13:0], and phys_addr equals phys_block × 16384 + blk_offset.
- R9: An I/O write to any port other than F0h to F4h changes no slot and no lock bit.
- R10: While cpu_wr is high, the write block is used. Otherwise the read block is used. ram_cs is high when cpu_rd or cpu_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor memory address |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O output strobe |
| io_port | input | 8 | Low byte of the I/O port address |
| io_data | input | 8 | I/O output data |
| phys_block | output | log2(BLOCK_COUNT) | Selected physical block |
| blk_offset | output | 14 | Offset within the block |
| phys_addr | output | log2(BLOCK_COUNT)+14 | Flat physical RAM address |
| ram_cs | output | 1 | RAM select |

## Verification
Every one of the 256 slot values is loaded into each of the four slots in turn. Each value is then tried with a read and with a write, once with its window locked and once unlocked. This separates the read field from the write field and the wide encoding from the legacy encoding, and it exercises the wrap of block numbers above 15. Lock writes alternate between having bits 3:0 clear and set, which shows that the low lock bits are ignored. Locking one window while a neighbour holds the same legacy value shows that each lock bit acts only on its own window. A write to a nearby unused port, followed by reads of every window, shows that the port decode is exact.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
   localparam int PAGE_BITS = 14;
   localparam int NUM_WIN   = 4;
   localparam int WIN_BITS  = 2;

   typedef struct packed {
      logic       wide;
      logic [6:0] body;
   } slot_t;

   function automatic logic [2:0] legacy_rd(input slot_t s);
      return s.body[6:4];
   endfunction

   function automatic logic [2:0] legacy_wr(input slot_t s);
      return s.body[2:0];
   endfunction
endpackage

// File: rtl/bank_slot_reg.sv
module bank_slot_reg
   import mmu_pkg::*;
#(
   parameter logic [7:0] PORT_ADDR = 8'hF0,
   parameter logic [7:0] RESET_VAL = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       io_wr,
   input  logic [7:0] io_port,
   input  logic [7:0] io_data,
   output slot_t      q
);
   logic hit;
   assign hit = io_wr && (io_port == PORT_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= slot_t'(RESET_VAL);
      else if (hit) q <= slot_t'(io_data);
   end

   a_r2_slot_load: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (q == $past(io_data)));
   a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(q));
endmodule

// File: rtl/bank_lock_reg.sv
module bank_lock_reg
   import mmu_pkg::*;
#(
   parameter logic [7:0] PORT_ADDR = 8'hF4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic [7:0]         io_port,
   input  logic [7:0]         io_data,
   output logic [NUM_WIN-1:0] lock
);
   logic hit;
   assign hit = io_wr && (io_port == PORT_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)   lock <= '0;
      else if (hit) lock <= io_data[7:4];
   end

   a_r6_lock_load: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (lock == $past(io_data[7:4])));
   a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(lock));
endmodule

// File: rtl/bank_resolve.sv
module bank_resolve
   import mmu_pkg::*;
#(
   parameter int BLOCK_COUNT = 16,
   localparam int BLK_W = $clog2(BLOCK_COUNT)
) (
   input  slot_t [NUM_WIN-1:0] slots,
   input  logic  [NUM_WIN-1:0] lock,
   input  logic  [WIN_BITS-1:0] win,
   input  logic                is_wr,
   output logic  [BLK_W-1:0]   block
);
   localparam logic [6:0] MASK = 7'(BLOCK_COUNT - 1);

   slot_t      cur;
   logic       cur_lock;
   logic [6:0] wide_blk;
   logic [2:0] leg_blk;

   always_comb begin
      cur      = slots[win];
      cur_lock = lock[win];
      wide_blk = cur.body & MASK;
      leg_blk  = (is_wr || cur_lock) ? legacy_wr(cur) : legacy_rd(cur);
      if (cur.wide) block = wide_blk[BLK_W-1:0];
      else          block = BLK_W'(leg_blk);
   end
endmodule

// File: rtl/mem_bank_mapper.sv
module mem_bank_mapper
   import mmu_pkg::*;
#(
   parameter int         BLOCK_COUNT = 16,
   parameter logic [7:0] PORT_BASE   = 8'hF0,
   localparam int BLK_W  = $clog2(BLOCK_COUNT),
   localparam int PHYS_W = BLK_W + PAGE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          cpu_addr,
   input  logic                 cpu_rd,
   input  logic                 cpu_wr,
   input  logic                 io_wr,
   input  logic [7:0]           io_port,
   input  logic [7:0]           io_data,
   output logic [BLK_W-1:0]     phys_block,
   output logic [PAGE_BITS-1:0] blk_offset,
   output logic [PHYS_W-1:0]    phys_addr,
   output logic                 ram_cs
);
   if (BLOCK_COUNT < 16 || BLOCK_COUNT > 128 ||
       (BLOCK_COUNT & (BLOCK_COUNT - 1)) != 0) begin : g_bad_count
      $error("BLOCK_COUNT must be a power of two from 16 to 128");
   end
   if (PORT_BASE > 8'hFB) begin : g_bad_base
      $error("PORT_BASE leaves no room for five ports");
   end

   slot_t [NUM_WIN-1:0] slots;
   logic  [NUM_WIN-1:0] lock;
   logic  [WIN_BITS-1:0] win;

   assign win = cpu_addr[15:14];

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_slot
      bank_slot_reg #(
         .PORT_ADDR (PORT_BASE + 8'(k)),
         .RESET_VAL (8'h80 | 8'(k))
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .io_wr   (io_wr),
         .io_port (io_port),
         .io_data (io_data),
         .q       (slots[k])
      );
   end

   bank_lock_reg #(.PORT_ADDR(PORT_BASE + 8'd4)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_wr   (io_wr),
      .io_port (io_port),
      .io_data (io_data),
      .lock    (lock)
   );

   bank_resolve #(.BLOCK_COUNT(BLOCK_COUNT)) u_resolve (
      .slots (slots),
      .lock  (lock),
      .win   (win),
      .is_wr (cpu_wr),
      .block (phys_block)
   );

   assign blk_offset = cpu_addr[PAGE_BITS-1:0];
   assign phys_addr  = {phys_block, blk_offset};
   assign ram_cs     = cpu_rd | cpu_wr;

   a_r5_legacy_low: assert property (@(posedge clk) disable iff (!rst_n)
      !slots[win].wide |-> (phys_block < BLK_W'(8)));
   a_r7_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!slots[win].wide && lock[win]) |->
         (phys_block == BLK_W'(slots[win].body[2:0])));
   a_r3_wide_same: assert property (@(posedge clk) disable iff (!rst_n)
      slots[win].wide |-> (phys_block == BLK_W'(slots[win].body)));
   a_r1_reset_map: assert property (@(posedge clk)
      !rst_n |=> (lock == '0));
endmodule

// File: tb/mem_bank_mapper_test.sv
module mem_bank_mapper_test;
   localparam int CLK_PERIOD = 10;
   localparam int BC = 16;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] cpu_addr = 0;
   logic        cpu_rd = 0, cpu_wr = 0, io_wr = 0;
   logic [7:0]  io_port = 0, io_data = 0;
   logic [3:0]  phys_block;
   logic [13:0] blk_offset;
   logic [17:0] phys_addr;
   logic        ram_cs;

   int checks = 0, fails = 0;

   mem_bank_mapper #(.BLOCK_COUNT(BC)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
      .phys_block(phys_block), .blk_offset(blk_offset),
      .phys_addr(phys_addr), .ram_cs(ram_cs)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic io_out(input logic [7:0] p, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1; io_port = p; io_data = d;
      @(negedge clk);
      io_wr = 0;
   endtask

   function automatic int exp_blk(input logic [7:0] v, input bit lk, input bit w);
      if (v[7]) return int'(v[6:0]) % BC;
      if (w || lk) return int'(v[2:0]);
      return int'(v[6:4]);
   endfunction

   task automatic access(input int k, input logic [13:0] off, input bit w);
      cpu_addr = {k[1:0], off};
      cpu_wr = w; cpu_rd = !w;
      #1;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset map, both directions
      for (int k = 0; k < 4; k++) begin
         for (int w = 0; w < 2; w++) begin
            access(k, 14'h0123, w[0]);
            chk("R1 reset block", phys_block, k);
         end
      end
      // R10 ram_cs
      cpu_rd = 0; cpu_wr = 0; #1;
      chk("R10 ram_cs idle", ram_cs, 0);
      cpu_rd = 1; #1;
      chk("R10 ram_cs read", ram_cs, 1);

      // Sweep: R2 R3 R4 R5 R6 R7 R8 R10
      for (int k = 0; k < 4; k++) begin
         for (int v = 0; v < 256; v++) begin
            io_out(8'hF0 + 8'(k), 8'(v));
            for (int lk = 0; lk < 2; lk++) begin
               // R6: bits 3:0 of the lock write alternate clear and set
               io_out(8'hF4, (lk != 0 ? (8'h10 << k) : 8'h00) | ((v & 1) != 0 ? 8'h0F : 8'h00));
               for (int w = 0; w < 2; w++) begin
                  logic [13:0] off;
                  int eb;
                  off = 14'((v * 37 + k * 101 + w * 7) & 16'h3FFF);
                  access(k, off, w[0]);
                  eb = exp_blk(8'(v), lk[0], w[0]);
                  chk("R3/R4/R5/R7/R10 block", phys_block, eb);
                  chk("R8 offset", blk_offset, off);
                  chk("R8 phys_addr", phys_addr, eb * 16384 + off);
               end
            end
         end
         io_out(8'hF0 + 8'(k), 8'h80 | 8'(k));
      end

      // R7: lock acts on its own window only
      io_out(8'hF4, 8'h00);
      io_out(8'hF0, 8'h52);
      io_out(8'hF1, 8'h52);
      io_out(8'hF4, 8'h10);
      access(0, 0, 0);
      chk("R7 locked window read", phys_block, 2);
      access(1, 0, 0);
      chk("R7 neighbour unlocked read", phys_block, 5);
      // R7: lock has no effect on wide encoding
      io_out(8'hF2, 8'h9B);
      io_out(8'hF4, 8'hF0);
      access(2, 0, 0);
      chk("R7 wide ignores lock", phys_block, 11);
      // R4: block 24 wraps to 8
      io_out(8'hF3, 8'h98);
      access(3, 0, 1);
      chk("R4 wrap 24->8", phys_block, 8);

      // R9: unrelated ports change nothing
      io_out(8'hF5, 8'h00);
      io_out(8'hEF, 8'h01);
      io_out(8'h70, 8'h00);
      access(0, 0, 0);
      chk("R9 slot0 kept", phys_block, 2);
      access(1, 0, 0);
      chk("R9 slot1 read kept", phys_block, 2);
      access(1, 0, 1);
      chk("R9 slot1 write kept", phys_block, 2);
      access(2, 0, 0);
      chk("R9 slot2 kept", phys_block, 11);
      access(3, 0, 0);
      chk("R9 slot3 kept", phys_block, 8);
      io_out(8'hF4, 8'h00);
      access(1, 0, 0);
      chk("R6 unlock restores read field", phys_block, 5);

      // R1: reset again restores map
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      for (int k = 0; k < 4; k++) begin
         access(k, 14'h3FFF, 0);
         chk("R1 reset after use", phys_block, k);
      end
      finish_run();
   end
endmodule